// File: doc/BRIEF.md
# Paged Register Access Port

This block is the slave side of an 8-bit processor bus. It gives the bus access to a large bank of control and status bytes through a 5-bit address. The top address bit splits the address space in two. With that bit low, the access reaches a single page register. With it high, the access reaches one of sixteen byte registers inside the page that register holds. Software loads the page once and then makes any number of register accesses within it. It reloads the page only when it moves to another page.

Fifteen pages are defined, numbered 1 to 15:

- Page 1 is control storage.
- Page 2 mirrors a 16-byte status vector supplied by the logic behind the block and cannot be written.
- Page 3 holds, at register 15, a fixed identification byte.
- All other register positions on pages 1 and 3 to 15 are plain read/write storage.

Page numbers 0 and 16 to 255 are undefined. Accesses take effect on the clock edge where chip select and a strobe are both high. Read data is registered.

Top module: `paged_reg_port`

## Requirements
- R1: A write with `addr[4]`=0 loads `wdata` into the page register, and `addr[3:0]` has no effect on that write.
- R2: A read with `addr[4]`=0 returns the current page number, whatever `addr[3:0]` holds.
- R3: The page number changes only on a page-register write; any number of register accesses leave it unchanged.
- R4: With `addr[4]`=1 on page 1 or pages 3 to 15, `addr[3:0]` selects a byte that a write stores and a later read returns. Every (page, register) pair is separate storage.
- R5: On page 2, a read of register k returns `stat_i[8*k+7:8*k]`, and writes are ignored.
- R6: Page 3, register 15 (address 5'h1F) always reads 8'h78, and writes to it are ignored.
- R7: On undefined pages (0 and above 15), register writes are ignored and register reads return 8'h00.
- R8: Nothing happens unless `cs` and a strobe are high at the clock edge. When `wr_en` and `rd_en` are both high, only the write takes place.
- R9: Read data appears on `rdata` after the clock edge that accepts the read, and holds until the next accepted read.
- R10: Reset (`rst_n` low) sets the page to 8'h00, clears all read/write storage and clears `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Chip select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Bit 4 selects page register (0) or in-page register (1); bits 3..0 pick the register |
| wdata | input | 8 | Write data |
| stat_i | input | 128 | Status bytes shown on page 2, byte k at bits 8k+7..8k |
| rdata | output | 8 | Registered read data |

## Verification
The embedded properties check four behaviours on every cycle:

- how the page register loads and holds;
- that `rdata` holds between accepted reads;
- the fixed identification value;
- the zero result on undefined pages.

They also check that every register write lands in the addressed storage cell. Only the bench's scenarios can show the following:

- that pages are kept apart from one another;
- that page 2 ignores writes and mirrors the status input;
- that low address bits are ignored on the page register;
- that reset clears the stored contents.

// File: rtl/pri_pkg.sv
package pri_pkg;
    localparam int DW        = 8;
    localparam int AW        = 5;
    localparam int RAW       = AW - 1;
    localparam int NREG      = 1 << RAW;
    localparam int PAGE_LAST = 15;
    localparam int STAT_PAGE = 2;
    localparam int ID_PAGE   = 3;
    localparam int ID_REG    = NREG - 1;
    localparam logic [DW-1:0] ID_CODE = 8'h78;
    localparam int NSLOT     = PAGE_LAST - 1;
    localparam int SLW       = $clog2(NSLOT + 2);

    typedef logic [DW-1:0] byte_t;

    typedef struct packed {
        byte_t page;
        byte_t rdata;
    } port_st_t;
endpackage

// File: rtl/pri_decode.sv
module pri_decode
    import pri_pkg::*;
(
    input  byte_t              page_i,
    input  logic [RAW-1:0]     reg_i,
    output logic               rw_o,
    output logic               stat_o,
    output logic               id_o,
    output logic [SLW-1:0]     slot_o
);
    byte_t slot_wide;

    always_comb begin
        stat_o = (page_i == byte_t'(STAT_PAGE));
        id_o   = (page_i == byte_t'(ID_PAGE)) && (reg_i == RAW'(ID_REG));
        rw_o   = (page_i >= byte_t'(1)) && (page_i <= byte_t'(PAGE_LAST))
                 && !stat_o && !id_o;
        // storage slots skip the status page
        if (page_i < byte_t'(STAT_PAGE))
            slot_wide = page_i - byte_t'(1);
        else
            slot_wide = page_i - byte_t'(2);
        slot_o = slot_wide[SLW-1:0];
    end
endmodule

// File: rtl/pri_regbank.sv
module pri_regbank
    import pri_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [SLW-1:0]     slot_i,
    input  logic [RAW-1:0]     reg_i,
    input  byte_t              wdata_i,
    output byte_t              rdata_o
);
    byte_t mem_q [NSLOT][NREG];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem_q[s][r] <= '0;
                else if (we_i && slot_i == SLW'(s) && reg_i == RAW'(r))
                    mem_q[s][r] <= wdata_i;
            end
        end
    end

    always_comb begin
        if (int'(slot_i) < NSLOT)
            rdata_o = mem_q[slot_i][reg_i];
        else
            rdata_o = '0;
    end

    // R4
    write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && int'(slot_i) < NSLOT) |=> mem_q[$past(slot_i)][$past(reg_i)] == $past(wdata_i));
endmodule

// File: rtl/paged_reg_port.sv
module paged_reg_port
    import pri_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    input  logic [NREG*DW-1:0] stat_i,
    output logic [DW-1:0]      rdata
);
    port_st_t st_d, st_q;

    logic           wr_fire, rd_fire, in_page;
    logic           sel_rw, sel_stat, sel_id;
    logic [SLW-1:0] slot;
    logic [RAW-1:0] reg_idx;
    byte_t          bank_rd;

    assign reg_idx = addr[RAW-1:0];
    assign in_page = addr[AW-1];
    assign wr_fire = cs && wr_en;
    assign rd_fire = cs && rd_en && !wr_en;

    pri_decode u_dec (
        .page_i (st_q.page),
        .reg_i  (reg_idx),
        .rw_o   (sel_rw),
        .stat_o (sel_stat),
        .id_o   (sel_id),
        .slot_o (slot)
    );

    pri_regbank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_fire && in_page && sel_rw),
        .slot_i  (slot),
        .reg_i   (reg_idx),
        .wdata_i (wdata),
        .rdata_o (bank_rd)
    );

    always_comb begin
        st_d = st_q;
        if (wr_fire && !in_page)
            st_d.page = wdata;
        if (rd_fire) begin
            if (!in_page)     st_d.rdata = st_q.page;
            else if (sel_id)  st_d.rdata = ID_CODE;
            else if (sel_stat) st_d.rdata = stat_i[reg_idx*DW +: DW];
            else if (sel_rw)  st_d.rdata = bank_rd;
            else              st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;

    // R1
    page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr_en && !addr[AW-1]) |=> st_q.page == $past(wdata));
    // R3
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && wr_en && !addr[AW-1]) |=> $stable(st_q.page));
    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd_en && !wr_en) |=> $stable(rdata));
    // R6
    id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd_en && !wr_en && addr == 5'h1F && st_q.page == 8'h03) |=> rdata == 8'h78);
    // R7
    undef_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd_en && !wr_en && addr[AW-1] && (st_q.page == 8'h00 || st_q.page > 8'h0F))
        |=> rdata == 8'h00);
endmodule

// File: tb/sim_paged_reg_port.sv
module sim_paged_reg_port;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]   addr = '0;
    logic [7:0]   wdata = '0;
    logic [127:0] stat_i;
    logic [7:0]   rdata;
    int errors = 0, checks = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    for (genvar k = 0; k < 16; k++) begin : g_stat
        assign stat_i[8*k +: 8] = 8'hA0 + 8'(k);
    end

    paged_reg_port u0 (.clk, .rst_n, .cs, .wr_en, .rd_en, .addr, .wdata, .stat_i, .rdata);

    // {req, wr, rd, addr, data, expected}
    localparam int NV = 30;
    localparam logic [26:0] VEC [NV] = '{
        {4'd1,  1'b1, 1'b0, 5'h00, 8'h01, 8'h00},
        {4'd4,  1'b1, 1'b0, 5'h10, 8'h5A, 8'h00},
        {4'd4,  1'b1, 1'b0, 5'h1F, 8'hC3, 8'h00},
        {4'd4,  1'b0, 1'b1, 5'h10, 8'h00, 8'h5A},   // R4
        {4'd4,  1'b0, 1'b1, 5'h1F, 8'h00, 8'hC3},   // R4
        {4'd2,  1'b0, 1'b1, 5'h00, 8'h00, 8'h01},   // R2
        {4'd1,  1'b1, 1'b0, 5'h05, 8'h02, 8'h00},
        {4'd1,  1'b0, 1'b1, 5'h07, 8'h00, 8'h02},   // R1 low bits ignored, R2
        {4'd5,  1'b1, 1'b0, 5'h13, 8'hFF, 8'h00},
        {4'd5,  1'b0, 1'b1, 5'h13, 8'h00, 8'hA3},   // R5
        {4'd5,  1'b0, 1'b1, 5'h1F, 8'h00, 8'hAF},   // R5
        {4'd1,  1'b1, 1'b0, 5'h00, 8'h03, 8'h00},
        {4'd6,  1'b0, 1'b1, 5'h1F, 8'h00, 8'h78},   // R6
        {4'd6,  1'b1, 1'b0, 5'h1F, 8'h11, 8'h00},
        {4'd6,  1'b0, 1'b1, 5'h1F, 8'h00, 8'h78},   // R6 write ignored
        {4'd4,  1'b1, 1'b0, 5'h10, 8'h66, 8'h00},
        {4'd4,  1'b0, 1'b1, 5'h10, 8'h00, 8'h66},   // R4
        {4'd7,  1'b1, 1'b0, 5'h00, 8'h00, 8'h00},
        {4'd7,  1'b1, 1'b0, 5'h14, 8'h77, 8'h00},
        {4'd7,  1'b0, 1'b1, 5'h14, 8'h00, 8'h00},   // R7 page 0
        {4'd7,  1'b1, 1'b0, 5'h00, 8'h10, 8'h00},
        {4'd7,  1'b1, 1'b0, 5'h12, 8'h33, 8'h00},
        {4'd7,  1'b0, 1'b1, 5'h12, 8'h00, 8'h00},   // R7 page 16
        {4'd2,  1'b0, 1'b1, 5'h00, 8'h00, 8'h10},   // R2
        {4'd4,  1'b1, 1'b0, 5'h00, 8'h0F, 8'h00},
        {4'd4,  1'b1, 1'b0, 5'h1A, 8'h9C, 8'h00},
        {4'd4,  1'b0, 1'b1, 5'h1A, 8'h00, 8'h9C},   // R4 last page
        {4'd3,  1'b1, 1'b0, 5'h00, 8'h01, 8'h00},
        {4'd3,  1'b0, 1'b1, 5'h10, 8'h00, 8'h5A},   // R3 page 1 kept apart
        {4'd4,  1'b0, 1'b1, 5'h1A, 8'h00, 8'h00}    // R4 no leak across pages
    };

    task automatic check(input int req, input logic [7:0] exp);
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL R%0d: rdata=%h expected=%h", req, rdata, exp);
        end
    endtask

    task automatic op(input logic c, input logic w, input logic r,
                      input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = c; wr_en = w; rd_en = r; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(10, 8'h00);                 // R10 rdata after reset
        rst_n = 1'b1;
        op(1, 0, 1, 5'h00, 8'h00); check(10, 8'h00);   // R10 page 00
        for (int i = 0; i < NV; i++) begin
            logic [26:0] v;
            v = VEC[i];
            op(1'b1, v[22], v[21], v[20:16], v[15:8]);
            if (v[21]) check(int'(v[26:23]), v[7:0]);
        end
        // R8: cs low blocks write and read
        op(0, 1, 0, 5'h10, 8'hEE);
        op(1, 0, 1, 5'h10, 8'h00); check(8, 8'h5A);
        op(0, 0, 1, 5'h00, 8'h00); check(8, 8'h5A);
        // R8: both strobes -> write only, rdata holds
        op(1, 1, 1, 5'h10, 8'h44); check(8, 8'h5A);
        op(1, 0, 1, 5'h10, 8'h00); check(8, 8'h44);
        // R9: held across idle cycles
        repeat (3) @(negedge clk);
        check(9, 8'h44);
        // R10: mid-run reset clears page and storage
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(10, 8'h00);
        op(1, 0, 1, 5'h00, 8'h00); check(10, 8'h00);
        op(1, 1, 0, 5'h00, 8'h01);
        op(1, 0, 1, 5'h10, 8'h00); check(10, 8'h00);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule